// File: doc/BRIEF.md
# Text-Mode Pixel Renderer with Block Mosaics

The renderer turns a pixel position into a single foreground/background bit for a character display. An external timing generator supplies the pixel column and row on every clock. The block works out which character cell the position falls in and reads that cell's 8-bit code from an on-chip screen buffer. It then produces the pixel from a computed 5x7 glyph pattern, or from a 2x3 block-mosaic pattern taken directly from the code bits.

Each cell is 6 pixels wide and 9 pixels tall. Ordinary glyphs use the top-left 5x7 pixels of the cell and leave a blank margin. The 64 codes reserved for mosaics instead split the whole cell into six solid 3x3 sub-blocks, one per on/off combination. Every pixel has the same two-clock latency from the coordinate inputs, whatever kind of code it comes from. A separate write port loads the screen buffer.

Top module: `txt_render`

## Requirements
- R1: While rst_ni is low, pix_o is 0.
- R2: pix_o shows, two clocks later, the pixel for the x_i/y_i/blank_i sampled at a clock edge. For an ordinary code k (0x00 to 0xBF), glyph row r (0 to 6) is the low 5 bits of (k + 3*r) mod 256. Glyph column c (0 to 4) is lit when bit 4-c of that row value is set.
- R3: The cell column is x_i/6 and the cell row is y_i/9. The buffer address is row*COLS + column. For an ordinary code, in-cell column 5 and in-cell rows 7 and 8 are always dark.
- R4: Codes whose two top bits are 11 (0xC0 to 0xFF, with 0xBF still ordinary) are mosaics. In-cell pixel (sx, sy) belongs to sub-block n = 2*(sy/3) + sx/3. The pixel is lit when bit n of the code is set.
- R5: When blank_i is 1, the pixel produced for that coordinate is 0, whatever the buffer holds.
- R6: A coordinate outside the screen (x_i >= 6*COLS or y_i >= 9*ROWS) produces a dark pixel.
- R7: A write of wr_data_i to wr_addr_i while wr_en_i is 1 changes the pixels rendered from coordinates sampled on any later clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| x_i | input | X_W (9) | Pixel column from the timing generator |
| y_i | input | Y_W (8) | Pixel row from the timing generator |
| blank_i | input | 1 | Forces the pixel dark |
| wr_en_i | input | 1 | Screen buffer write strobe |
| wr_addr_i | input | A_W (11) | Screen buffer write address, row*COLS+column |
| wr_data_i | input | 8 | Character code to store |
| pix_o | output | 1 | Foreground (1) or background (0) pixel |

## Verification
The buffer is filled with a stride pattern so that all 256 codes appear, including the 0xBF/0xC0 boundary. Every pixel of the full screen is then streamed back to back, one per clock. A wrong glyph row, a wrong mosaic sub-block, a shifted cell boundary or a skewed pipeline each shows up as a mismatch on a particular class of pixel (glyph, margin or mosaic). Blanked and off-screen sweeps over buffer contents that would otherwise be lit separate the forcing paths from the lookup. Rewriting one cell and rendering it again shows that the write port reaches the read path.

// File: rtl/txt_render_pkg.sv
package txt_render_pkg;
  localparam int CODE_W  = 8;
  localparam int GLYPH_W = 5;
  localparam int GLYPH_H = 7;
  localparam int BLK     = 3;
  localparam int CELL_W  = 2 * BLK;
  localparam int CELL_H  = 3 * BLK;
  localparam int SX_W    = $clog2(CELL_W);
  localparam int SY_W    = $clog2(CELL_H);
  localparam logic [1:0] MOSAIC_TAG = 2'b11;

  typedef logic [CODE_W-1:0]  code_t;
  typedef logic [GLYPH_W-1:0] glyph_row_t;

  function automatic glyph_row_t glyph_row(code_t code, logic [2:0] row);
    code_t s;
    s = code + code_t'(3 * int'(row));
    return s[GLYPH_W-1:0];
  endfunction

  function automatic logic is_mosaic(code_t code);
    return code[CODE_W-1 -: 2] == MOSAIC_TAG;
  endfunction
endpackage

// File: rtl/txt_cell_addr.sv
module txt_cell_addr
  import txt_render_pkg::*;
#(
  parameter int COLS = 80,
  parameter int ROWS = 25,
  parameter int X_W  = 9,
  parameter int Y_W  = 8,
  parameter int A_W  = 11
) (
  input  logic [X_W-1:0]  x_i,
  input  logic [Y_W-1:0]  y_i,
  output logic [A_W-1:0]  addr_o,
  output logic [SX_W-1:0] sub_x_o,
  output logic [SY_W-1:0] sub_y_o,
  output logic            valid_o
);
  int unsigned col, row;

  always_comb begin
    col     = int'(x_i) / CELL_W;
    row     = int'(y_i) / CELL_H;
    sub_x_o = SX_W'(int'(x_i) % CELL_W);
    sub_y_o = SY_W'(int'(y_i) % CELL_H);
    valid_o = (col < COLS) && (row < ROWS);
    addr_o  = valid_o ? A_W'(row * COLS + col) : '0;
  end
endmodule

// File: rtl/txt_screen_ram.sv
module txt_screen_ram
  import txt_render_pkg::*;
#(
  parameter int DEPTH = 2000,
  parameter int A_W   = 11
) (
  input  logic           clk_i,
  input  logic           we_i,
  input  logic [A_W-1:0] waddr_i,
  input  code_t          wdata_i,
  input  logic [A_W-1:0] raddr_i,
  output code_t          rdata_o
);
  code_t mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i && (int'(waddr_i) < DEPTH)) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/txt_glyph_rom.sv
module txt_glyph_rom
  import txt_render_pkg::*;
(
  input  code_t      code_i,
  input  logic [2:0] row_i,
  output glyph_row_t bits_o
);
  always_comb bits_o = glyph_row(code_i, row_i);
endmodule

// File: rtl/txt_pixel_sel.sv
module txt_pixel_sel
  import txt_render_pkg::*;
(
  input  code_t           code_i,
  input  glyph_row_t      glyph_i,
  input  logic [SX_W-1:0] sub_x_i,
  input  logic [SY_W-1:0] sub_y_i,
  input  logic            valid_i,
  input  logic            blank_i,
  output logic            pix_o
);
  logic       bx;
  logic [1:0] by;
  logic [2:0] blk_n;
  logic [2:0] gcol;
  logic       in_glyph, mos_bit, gly_bit;

  always_comb begin
    bx       = int'(sub_x_i) >= BLK;
    by       = (int'(sub_y_i) < BLK) ? 2'd0 : (int'(sub_y_i) < 2 * BLK) ? 2'd1 : 2'd2;
    blk_n    = {by, 1'b0} + {2'b00, bx};
    mos_bit  = code_i[blk_n];
    in_glyph = (int'(sub_x_i) < GLYPH_W) && (int'(sub_y_i) < GLYPH_H);
    gcol     = 3'(GLYPH_W - 1) - 3'(sub_x_i);
    gly_bit  = in_glyph ? glyph_i[gcol] : 1'b0;
    if (blank_i || !valid_i) pix_o = 1'b0;
    else if (is_mosaic(code_i)) pix_o = mos_bit;
    else pix_o = gly_bit;
  end
endmodule

// File: rtl/txt_render.sv
module txt_render
  import txt_render_pkg::*;
#(
  parameter int COLS = 80,
  parameter int ROWS = 25,
  localparam int X_W = $clog2(COLS * CELL_W),
  localparam int Y_W = $clog2(ROWS * CELL_H),
  localparam int DEPTH = COLS * ROWS,
  localparam int A_W = $clog2(DEPTH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [X_W-1:0] x_i,
  input  logic [Y_W-1:0] y_i,
  input  logic           blank_i,
  input  logic           wr_en_i,
  input  logic [A_W-1:0] wr_addr_i,
  input  logic [7:0]     wr_data_i,
  output logic           pix_o
);
  logic [A_W-1:0]  rd_addr;
  logic [SX_W-1:0] sub_x, s1_sub_x;
  logic [SY_W-1:0] sub_y, s1_sub_y;
  logic            valid, s1_valid, s1_blank;
  code_t           cell_code;
  glyph_row_t      glyph_bits;
  logic            pix_d;

  txt_cell_addr #(.COLS(COLS), .ROWS(ROWS), .X_W(X_W), .Y_W(Y_W), .A_W(A_W)) u_addr (
    .x_i(x_i), .y_i(y_i), .addr_o(rd_addr),
    .sub_x_o(sub_x), .sub_y_o(sub_y), .valid_o(valid)
  );

  txt_screen_ram #(.DEPTH(DEPTH), .A_W(A_W)) u_ram (
    .clk_i(clk_i), .we_i(wr_en_i), .waddr_i(wr_addr_i), .wdata_i(wr_data_i),
    .raddr_i(rd_addr), .rdata_o(cell_code)
  );

  // stage 1: coordinates travel beside the synchronous buffer read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_sub_x <= '0;
      s1_sub_y <= '0;
      s1_valid <= 1'b0;
      s1_blank <= 1'b1;
    end else begin
      s1_sub_x <= sub_x;
      s1_sub_y <= sub_y;
      s1_valid <= valid;
      s1_blank <= blank_i;
    end
  end

  txt_glyph_rom u_rom (
    .code_i(cell_code), .row_i(s1_sub_y[2:0]), .bits_o(glyph_bits)
  );

  txt_pixel_sel u_sel (
    .code_i(cell_code), .glyph_i(glyph_bits), .sub_x_i(s1_sub_x), .sub_y_i(s1_sub_y),
    .valid_i(s1_valid), .blank_i(s1_blank), .pix_o(pix_d)
  );

  // stage 2: output register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pix_o <= 1'b0;
    else         pix_o <= pix_d;
  end
endmodule

// File: rtl/txt_render_chk.sv
module txt_render_chk
  import txt_render_pkg::*;
#(
  parameter int COLS = 80,
  parameter int ROWS = 25,
  parameter int X_W  = 9,
  parameter int Y_W  = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [X_W-1:0]  x_i,
  input logic [Y_W-1:0]  y_i,
  input logic            blank_i,
  input logic            pix_o,
  input code_t           s1_code,
  input logic [SX_W-1:0] s1_sub_x,
  input logic [SY_W-1:0] s1_sub_y,
  input logic            s1_valid,
  input logic            s1_blank
);
  logic [1:0] warm;
  logic       on_screen, s1_live, s1_margin, lit;
  int         n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        warm <= '0;
    else if (warm != 2) warm <= warm + 2'd1;
  end

  always_comb begin
    on_screen = (int'(x_i) < COLS * CELL_W) && (int'(y_i) < ROWS * CELL_H);
    s1_live   = s1_valid && !s1_blank;
    s1_margin = (int'(s1_sub_x) >= GLYPH_W) || (int'(s1_sub_y) >= GLYPH_H);
    n         = 2 * (int'(s1_sub_y) / BLK) + int'(s1_sub_x) / BLK;
    lit       = s1_code[n[2:0]];
  end

  p_reset_dark_r1: assert property (@(posedge clk_i) !rst_ni |-> !pix_o);

  p_margin_dark_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_live && !is_mosaic(s1_code) && s1_margin) |=> !pix_o);

  p_mosaic_bit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_live && is_mosaic(s1_code)) |=> pix_o == $past(lit));

  p_blank_dark_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm == 2 && $past(blank_i, 2)) |-> !pix_o);

  p_offscreen_dark_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm == 2 && !$past(on_screen, 2)) |-> !pix_o);
endmodule

bind txt_render txt_render_chk #(.COLS(COLS), .ROWS(ROWS), .X_W(X_W), .Y_W(Y_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .x_i(x_i), .y_i(y_i), .blank_i(blank_i), .pix_o(pix_o),
  .s1_code(cell_code), .s1_sub_x(s1_sub_x), .s1_sub_y(s1_sub_y),
  .s1_valid(s1_valid), .s1_blank(s1_blank)
);

// File: tb/txt_render_test.sv
`timescale 1ns/1ps
module txt_render_test;
  localparam int COLS = 80, ROWS = 25;
  localparam int XMAX = COLS * 6, YMAX = ROWS * 9, DEPTH = COLS * ROWS;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [8:0]  x_i = '0;
  logic [7:0]  y_i = '0;
  logic        blank_i = 1'b1;
  logic        wr_en_i = 1'b0;
  logic [10:0] wr_addr_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic        pix_o;

  int total = 0, bad = 0;
  int shadow [DEPTH];
  int exp_d1 = 0, exp_d2 = 0;
  bit vld_d1 = 0, vld_d2 = 0;
  string tag_d1 = "", tag_d2 = "";
  bit done = 0;

  always #5 clk_i = ~clk_i;

  txt_render #(.COLS(COLS), .ROWS(ROWS)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .x_i(x_i), .y_i(y_i), .blank_i(blank_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .pix_o(pix_o)
  );

  function automatic int ref_pix(int x, int y, bit blk, output string tag);
    int sx, sy, k, p;
    if (blk) begin tag = "R5"; return 0; end
    if (x >= XMAX || y >= YMAX) begin tag = "R6"; return 0; end
    sx = x % 6; sy = y % 9;
    k  = shadow[(y / 9) * COLS + x / 6];
    if (k >= 8'hC0) begin
      tag = "R4";
      return (k >> (2 * (sy / 3) + sx / 3)) & 1;
    end
    if (sx >= 5 || sy >= 7) begin tag = "R3"; return 0; end
    tag = "R2";
    p = ((k + 3 * sy) % 256) % 32;
    return (p >> (4 - sx)) & 1;
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: pix_o=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one coordinate per clock; pix_o at this negedge belongs to the coordinate two negedges back
  task automatic step(int x, int y, bit blk, bit chk);
    string t;
    int e;
    @(negedge clk_i);
    if (vld_d2) check(tag_d2, int'(pix_o), exp_d2);
    exp_d2 = exp_d1; vld_d2 = vld_d1; tag_d2 = tag_d1;
    e = ref_pix(x, y, blk, t);
    exp_d1 = e; vld_d1 = chk; tag_d1 = t;
    x_i = 9'(x); y_i = 8'(y); blank_i = blk;
  endtask

  task automatic flush();
    step(0, 0, 1, 0);
    step(0, 0, 1, 0);
  endtask

  task automatic write_cell(int a, int code);
    @(negedge clk_i);
    wr_en_i = 1; wr_addr_i = 11'(a); wr_data_i = 8'(code);
    shadow[a] = code;
    @(negedge clk_i);
    wr_en_i = 0;
  endtask

  task automatic render_cell(int col, int row);
    for (int yy = 0; yy < 9; yy++)
      for (int xx = 0; xx < 6; xx++)
        step(col * 6 + xx, row * 9 + yy, 0, 1);
    flush();
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) begin
      @(posedge clk_i);
      if (done) break;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: output dark throughout reset
    repeat (3) @(negedge clk_i);
    check("R1", int'(pix_o), 0);
    rst_ni = 1'b1;
    // fill: stride pattern reaches every code, 0xBF and 0xC0 included
    @(negedge clk_i);
    wr_en_i = 1;
    for (int a = 0; a < DEPTH; a++) begin
      wr_addr_i = 11'(a);
      wr_data_i = 8'((a * 37 + a / COLS) % 256);
      shadow[a] = (a * 37 + a / COLS) % 256;
      @(negedge clk_i);
    end
    wr_en_i = 0;
    // R2/R3/R4: every on-screen pixel, streamed
    for (int y = 0; y < YMAX; y++)
      for (int x = 0; x < XMAX; x++)
        step(x, y, 0, 1);
    flush();
    // R5: blanked region over lit content
    for (int y = 0; y < 18; y++)
      for (int x = 0; x < 60; x++)
        step(x, y, 1, 1);
    flush();
    // R6: coordinates past the right and bottom edges
    for (int y = 0; y < 12; y++)
      for (int x = XMAX - 6; x < 512; x++)
        step(x, y, 0, 1);
    for (int y = YMAX - 3; y < 256; y++)
      for (int x = 0; x < 24; x++)
        step(x, y, 0, 1);
    flush();
    // R7: rewrite one cell, render before and after
    write_cell(2 * COLS + 3, 8'hC5);
    render_cell(3, 2);
    write_cell(2 * COLS + 3, 8'h41);
    render_cell(3, 2);
    write_cell(0, 8'hFF);
    render_cell(0, 0);
    write_cell(DEPTH - 1, 8'hBF);
    render_cell(COLS - 1, ROWS - 1);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule